// File: doc/BRIEF.md
# Set-Associative Write-Back Cache

This block is a parameterized cache between a processor-side request port and a line-wide memory port. The address is split into tag, set index and byte offset. Every way of the indexed set is compared at once. A read hit returns 1, 2 or 4 bytes taken from the offset. A write hit merges the bytes into the cached line and marks that line dirty. Memory is not touched on either kind of hit.

On a miss a victim way is chosen: an empty way if the set has one, otherwise the least recently used way. A dirty victim is first sent to memory as one full-line write. The missing line is then requested and installed. After the fill the request runs through the lookup again and now hits. A write miss therefore allocates the line and then merges into it. The processor port accepts one request at a time and holds its ready low until the response cycle. Memory latency may be any length: requests use a valid/ready handshake and the line arrives with a response strobe.

Top module: `cache_top`

## Requirements
- R1: The address is split, from the top down, into a tag of ADDR_W − log2(SETS) − log2(LINE_BYTES) bits, a set index and a byte offset. A read returns the bytes starting at the offset, the lowest-addressed byte in bits 7:0, zero-extended. Size code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes.
- R2: After reset every line is invalid and `cpuReqReady` is 1, while `cpuRespValid` and `memReqValid` are 0. The first access to any line misses.
- R3: A hit needs a valid line in the indexed set whose stored tag equals the address tag. `cpuRespValid` then rises in the second cycle after the request is accepted, and no memory request is made.
- R4: A read miss issues exactly one line read. The address of that read is the request address with the offset bits cleared. The response returns data from the refilled line.
- R5: The victim is the lowest-numbered invalid way of the set. If no way is invalid, the victim is the least recently used way, where both hits and fills count as uses.
- R6: A write hit changes only the addressed bytes of the cached line, makes no memory request and marks the line dirty.
- R7: A dirty victim is written back as a full line at its own line address, holding its latest contents, before the refill read is requested. A clean victim is never written back.
- R8: A write miss loads the line from memory and then merges the written bytes into it. Later reads see the merged bytes.
- R9: `cpuReqReady` is low from the cycle after acceptance until the response. `cpuRespValid` is a single-cycle pulse, one per request.
- R10: While `memReqValid` is high and `memReqReady` is low, the memory request keeps its address and direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqReady | output | 1 | Cache can accept a request |
| cpuReqWrite | input | 1 | 1 = write, 0 = read |
| cpuReqAddr | input | ADDR_W | Byte address, aligned to the access size |
| cpuReqSize | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes |
| cpuReqWdata | input | 32 | Write bytes, lowest address in bits 7:0 |
| cpuRespValid | output | 1 | Response pulse |
| cpuRespRdata | output | 32 | Read data, zero-extended |
| memReqValid | output | 1 | Memory line request present |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = write-back, 0 = refill read |
| memReqAddr | output | ADDR_W | Line-aligned address |
| memReqData | output | LINE_BYTES*8 | Victim line for a write-back |
| memRespValid | input | 1 | Refill line present |
| memRespData | input | LINE_BYTES*8 | Refill line contents |

## Verification
A wrong tag, valid or LRU state shows up as an extra or missing memory read, or as a write-back of the wrong line. The memory model sees this when the request is accepted. It is visible at the latest on the next access to the affected set. Lost dirty state or bad merging shows up as stale bytes, either in a write-back, which is compared against a byte-level reference at the moment it is accepted, or in a later read of the same address. Timing faults in the handshake show up within one cycle as a response at the wrong latency or a ready that does not drop.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef struct packed {
    logic latch;   // capture processor request
    logic access;  // perform hit: read capture / write merge / LRU touch
    logic fill;    // install refill line into victim way
    logic selWb;   // memory address points at the victim line
  } cacheStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WBACK, ST_FILLREQ, ST_FILLWAIT, ST_RESP
  } cacheState_t;
endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cacheStrobes_t           stb,
  input  logic                    cpuReqWrite,
  input  logic [ADDR_W-1:0]       cpuReqAddr,
  input  logic [1:0]              cpuReqSize,
  input  logic [31:0]             cpuReqWdata,
  output logic                    hit,
  output logic                    victimDirty,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [LINE_BYTES*8-1:0] memReqData,
  input  logic [LINE_BYTES*8-1:0] memRespData,
  output logic [31:0]             rdata
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LINE_W = LINE_BYTES * 8;

  logic              reqWrite;
  logic [ADDR_W-1:0] reqAddr;
  logic [1:0]        reqSize;
  logic [31:0]       reqWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWrite <= 1'b0;
      reqAddr  <= '0;
      reqSize  <= '0;
      reqWdata <= '0;
    end else if (stb.latch) begin
      reqWrite <= cpuReqWrite;
      reqAddr  <= cpuReqAddr;
      reqSize  <= cpuReqSize;
      reqWdata <= cpuReqWdata;
    end
  end

  logic [TAG_W-1:0] reqTag;
  logic [SET_W-1:0] reqSet;
  logic [OFF_W-1:0] reqOff;
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet = reqAddr[OFF_W +: SET_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  logic              validQ [SETS][WAYS];
  logic              dirtyQ [SETS][WAYS];
  logic [TAG_W-1:0]  tagQ   [SETS][WAYS];
  logic [LINE_W-1:0] lineQ  [SETS][WAYS];

  // parallel tag comparators, one per way
  logic [WAYS-1:0] hitVec;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validQ[reqSet][w] && (tagQ[reqSet][w] == reqTag);
  end
  assign hit = |hitVec;

  logic [WAY_W-1:0] hitWay, lruWay, victimWay;
  always_comb begin
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (hitVec[w]) hitWay = WAY_W'(w);
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    victimWay = lruWay;
    for (int w = 0; w < WAYS; w++)
      if (!found && !validQ[reqSet][w]) begin
        victimWay = WAY_W'(w);
        found     = 1'b1;
      end
  end

  // replacement order state
  if (WAYS == 2) begin : g_lruBit
    logic lruQ [SETS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++) lruQ[s] <= 1'b0;
      end else if (stb.access) begin
        lruQ[reqSet] <= ~hitWay[0];
      end
    end
    assign lruWay = WAY_W'(lruQ[reqSet]);
  end else begin : g_lruAge
    logic [WAY_W-1:0] ageQ [SETS][WAYS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) ageQ[s][w] <= WAY_W'(w);
      end else if (stb.access) begin
        for (int w = 0; w < WAYS; w++)
          if (WAY_W'(w) == hitWay) ageQ[reqSet][w] <= '0;
          else if (ageQ[reqSet][w] < ageQ[reqSet][hitWay])
            ageQ[reqSet][w] <= ageQ[reqSet][w] + 1'b1;
      end
    end
    always_comb begin
      lruWay = '0;
      for (int w = 0; w < WAYS; w++)
        if (ageQ[reqSet][w] == WAY_W'(WAYS - 1)) lruWay = WAY_W'(w);
    end
  end

  // read extraction and write merge on the hit line
  logic [LINE_W-1:0] hitLine, shifted, mergedLine;
  logic [31:0]       sizeMask;
  assign hitLine = lineQ[reqSet][hitWay];
  assign shifted = hitLine >> {reqOff, 3'b000};
  always_comb begin
    case (reqSize)
      2'd0:    sizeMask = 32'h0000_00FF;
      2'd1:    sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  always_comb begin
    int rel;
    int nBytes;
    nBytes     = (reqSize == 2'd0) ? 1 : (reqSize == 2'd1) ? 2 : 4;
    mergedLine = hitLine;
    for (int b = 0; b < LINE_BYTES; b++) begin
      rel = b - int'(reqOff);
      if (rel >= 0 && rel < nBytes)
        mergedLine[b*8 +: 8] = reqWdata[rel*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (stb.access) rdata <= shifted[31:0] & sizeMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          validQ[s][w] <= 1'b0;
          dirtyQ[s][w] <= 1'b0;
        end
    end else if (stb.fill) begin
      validQ[reqSet][victimWay] <= 1'b1;
      dirtyQ[reqSet][victimWay] <= 1'b0;
    end else if (stb.access && reqWrite) begin
      dirtyQ[reqSet][hitWay] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.fill) begin
      tagQ[reqSet][victimWay]  <= reqTag;
      lineQ[reqSet][victimWay] <= memRespData;
    end else if (stb.access && reqWrite) begin
      lineQ[reqSet][hitWay] <= mergedLine;
    end
  end

  assign victimDirty = validQ[reqSet][victimWay] && dirtyQ[reqSet][victimWay];
  assign memReqData  = lineQ[reqSet][victimWay];
  assign memReqAddr  = stb.selWb ? {tagQ[reqSet][victimWay], reqSet, {OFF_W{1'b0}}}
                                 : {reqTag, reqSet, {OFF_W{1'b0}}};
endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReqValid,
  input  logic          hit,
  input  logic          victimDirty,
  input  logic          memReqReady,
  input  logic          memRespValid,
  output cacheStrobes_t stb,
  output logic          cpuReqReady,
  output logic          cpuRespValid,
  output logic          memReqValid,
  output logic          memReqWrite
);
  cacheState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:     if (cpuReqValid) stateNext = ST_LOOKUP;
      ST_LOOKUP:   stateNext = hit ? ST_RESP : (victimDirty ? ST_WBACK : ST_FILLREQ);
      ST_WBACK:    if (memReqReady) stateNext = ST_FILLREQ;
      ST_FILLREQ:  if (memReqReady) stateNext = ST_FILLWAIT;
      ST_FILLWAIT: if (memRespValid) stateNext = ST_LOOKUP;
      ST_RESP:     stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  assign stb.latch    = (state == ST_IDLE) && cpuReqValid;
  assign stb.access   = (state == ST_LOOKUP) && hit;
  assign stb.fill     = (state == ST_FILLWAIT) && memRespValid;
  assign stb.selWb    = (state == ST_WBACK);
  assign cpuReqReady  = (state == ST_IDLE);
  assign cpuRespValid = (state == ST_RESP);
  assign memReqValid  = (state == ST_WBACK) || (state == ST_FILLREQ);
  assign memReqWrite  = (state == ST_WBACK);
endmodule

// File: rtl/cache_top.sv
module cache_top
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReqValid,
  output logic                    cpuReqReady,
  input  logic                    cpuReqWrite,
  input  logic [ADDR_W-1:0]       cpuReqAddr,
  input  logic [1:0]              cpuReqSize,
  input  logic [31:0]             cpuReqWdata,
  output logic                    cpuRespValid,
  output logic [31:0]             cpuRespRdata,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic                    memReqWrite,
  output logic [ADDR_W-1:0]       memReqAddr,
  output logic [LINE_BYTES*8-1:0] memReqData,
  input  logic                    memRespValid,
  input  logic [LINE_BYTES*8-1:0] memRespData
);
  cacheStrobes_t stb;
  logic hit, victimDirty;

  cache_control ctrl_i (
    .clk, .rstN, .cpuReqValid, .hit, .victimDirty, .memReqReady, .memRespValid,
    .stb, .cpuReqReady, .cpuRespValid, .memReqValid, .memReqWrite
  );

  cache_datapath #(
    .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)
  ) dp_i (
    .clk, .rstN, .stb, .cpuReqWrite, .cpuReqAddr, .cpuReqSize, .cpuReqWdata,
    .hit, .victimDirty, .memReqAddr, .memReqData, .memRespData,
    .rdata(cpuRespRdata)
  );
endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReqValid,
  input logic              cpuReqReady,
  input logic              cpuRespValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  // R3
  accept_no_early_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady) |=> !cpuRespValid);

  // R9
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady) |=> !cpuReqReady);

  // R9
  resp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |=> !cpuRespValid);

  // R9
  resp_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |-> !cpuReqReady);

  // R4
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[OFF_W-1:0] == '0));

  // R7
  wb_then_refill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && memReqReady) |=> (memReqValid && !memReqWrite));

  // R10
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));
endmodule

bind cache_top cache_checker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady),
  .cpuRespValid(cpuRespValid), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr)
);

// File: tb/cache_top_tb_top.sv
module cache_top_tb_top;
  localparam int ADDR_W = 10;
  localparam int LB     = 8;
  localparam int MEM_N  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cpuReqValid = 1'b0, cpuReqWrite = 1'b0;
  logic              cpuReqReady, cpuRespValid;
  logic [ADDR_W-1:0] cpuReqAddr = '0;
  logic [1:0]        cpuReqSize = '0;
  logic [31:0]       cpuReqWdata = '0, cpuRespRdata;
  logic              memReqValid, memReqWrite;
  logic              memReqReady = 1'b0, memRespValid = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic [LB*8-1:0]   memReqData, memRespData = '0;

  always #4 clk = ~clk;

  cache_top #(.ADDR_W(ADDR_W), .SETS(4), .WAYS(2), .LINE_BYTES(LB)) dut_i (
    .clk, .rstN, .cpuReqValid, .cpuReqReady, .cpuReqWrite, .cpuReqAddr, .cpuReqSize,
    .cpuReqWdata, .cpuRespValid, .cpuRespRdata, .memReqValid, .memReqReady,
    .memReqWrite, .memReqAddr, .memReqData, .memRespValid, .memRespData
  );

  logic [7:0] memArr [MEM_N];
  logic [7:0] refArr [MEM_N];
  int checks = 0, errors = 0, memReads = 0, memWrites = 0;
  int lastWbAddr = -1;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input int addr, input int size);
    logic [31:0] v = '0;
    for (int b = 0; b < (1 << size); b++) v[b*8 +: 8] = refArr[addr + b];
    return v;
  endfunction

  // memory model
  initial begin
    int pendDelay = -1;
    int pendAddr  = 0;
    forever begin
      @(negedge clk);
      memRespValid = 1'b0;
      if (pendDelay > 0) pendDelay--;
      else if (pendDelay == 0) begin
        for (int b = 0; b < LB; b++) memRespData[b*8 +: 8] = memArr[pendAddr + b];
        memRespValid = 1'b1;
        pendDelay = -1;
      end
      memReqReady = rstN && ($urandom % 3 != 0);
      if (memReqValid && memReqReady) begin
        chk(memReqAddr % LB == 0, "R4", "line aligned address", memReqAddr, 0);
        if (memReqWrite) begin
          logic [LB*8-1:0] expLine;
          memWrites++;
          lastWbAddr = memReqAddr;
          for (int b = 0; b < LB; b++) begin
            expLine[b*8 +: 8] = refArr[memReqAddr + b];
            memArr[memReqAddr + b] = memReqData[b*8 +: 8];
          end
          chk(memReqData == expLine, "R7", "write-back line data", memReqData, expLine);
        end else begin
          memReads++;
          pendAddr  = memReqAddr;
          pendDelay = $urandom % 3;
        end
      end
    end
  end

  // one processor access; returns data and cycles from acceptance to response
  task automatic access(input bit wr, input int addr, input int size, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    if (wr) for (int b = 0; b < (1 << size); b++) refArr[addr + b] = wd[b*8 +: 8];
    cpuReqValid = 1'b1; cpuReqWrite = wr; cpuReqAddr = ADDR_W'(addr);
    cpuReqSize = 2'(size); cpuReqWdata = wd;
    while (!cpuReqReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpuReqValid = 1'b0;
    lat = 1;
    while (!cpuRespValid) begin
      if (cpuReqReady) chk(0, "R9", "ready while busy", 1, 0);
      @(negedge clk);
      lat++;
    end
    rd = cpuRespRdata;
  endtask

  task automatic doRead(input int addr, input int size, input string req,
                        output int lat);
    logic [31:0] rd;
    access(0, addr, size, 32'h0, rd, lat);
    chk(rd == expRead(addr, size), req, $sformatf("read @%0h", addr), rd, expRead(addr, size));
  endtask

  initial begin
    int lat, r0, w0;
    logic [31:0] rd;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_N; i++) begin
      memArr[i] = 8'(i * 37 + 5);
      refArr[i] = memArr[i];
    end
    repeat (4) @(negedge clk);
    chk(cpuReqReady == 1'b1, "R2", "ready in reset", cpuReqReady, 1);
    chk(cpuRespValid == 1'b0, "R2", "resp in reset", cpuRespValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cpuReqReady == 1'b1, "R2", "ready after reset", cpuReqReady, 1);
    chk(memReqValid == 1'b0, "R2", "mem idle after reset", memReqValid, 0);

    // set 0 lines: A=0x000, B=0x020, C=0x040 (tag in bits 9:5, set in 4:3)
    r0 = memReads;
    doRead(32'h004, 2, "R4", lat);
    chk(memReads == r0 + 1, "R2", "cold access refills", memReads - r0, 1);
    access(1, 32'h000, 2, 32'hDEAD_BEEF, rd, lat);
    chk(memReads == r0 + 1, "R6", "write hit no refill", memReads - r0, 1);
    chk(memWrites == 0, "R6", "write hit no write-back", memWrites, 0);
    r0 = memReads;
    access(1, 32'h022, 1, 32'h0000_A55A, rd, lat);
    chk(memReads == r0 + 1, "R8", "write miss refills", memReads - r0, 1);
    chk(memWrites == 0, "R5", "invalid way used, no eviction", memWrites, 0);
    doRead(32'h020, 2, "R8", lat);
    r0 = memReads;
    doRead(32'h000, 2, "R3", lat);
    chk(lat == 2, "R3", "hit latency", lat, 2);
    chk(memReads == r0, "R3", "hit no memory read", memReads - r0, 0);
    doRead(32'h001, 0, "R1", lat);
    doRead(32'h002, 1, "R1", lat);
    doRead(32'h005, 0, "R1", lat);
    // C misses: LRU is B (dirty) -> write-back of 0x020 then refill
    r0 = memReads; w0 = memWrites;
    doRead(32'h040, 2, "R4", lat);
    chk(memWrites == w0 + 1, "R7", "dirty victim written back", memWrites - w0, 1);
    chk(lastWbAddr == 32'h020, "R5", "LRU victim address", lastWbAddr, 32'h020);
    chk(memReads == r0 + 1, "R4", "one refill read", memReads - r0, 1);
    r0 = memReads;
    doRead(32'h000, 2, "R5", lat);
    chk(memReads == r0, "R5", "recently used line kept", memReads - r0, 0);
    // B misses: victim C is clean -> no write-back
    w0 = memWrites;
    doRead(32'h024, 2, "R7", lat);
    chk(memWrites == w0, "R7", "clean victim not written", memWrites - w0, 0);
    doRead(32'h022, 1, "R8", lat);

    // constrained random traffic over all sets and many tags
    for (int i = 0; i < 500; i++) begin
      int sz, ad;
      sz = $urandom % 3;
      ad = ($urandom % MEM_N) & ~((1 << sz) - 1);
      if ($urandom % 2) access(1, ad, sz, $urandom, rd, lat);
      else doRead(ad, sz, "R1", lat);
    end
    chk(memWrites > 0, "R7", "random traffic evicted dirty lines", memWrites, 1);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule